// File: doc/BRIEF.md
# Programmable AND-OR Product Array

This block is the logic core of a small programmable logic device. Twenty array sources feed it: four dedicated input pins and sixteen feedback lines, one from each macrocell. Every source becomes two literals, its true value and its inverse. Each product term holds one connection bit for each literal and forms the AND of the literals it connects. Each of the sixteen macrocells owns nine product terms. The first eight are ORed together on a fixed wiring to give that macrocell's sum. The ninth term leaves the block on its own line for clock or output-enable use.

Connection bits follow the erased-cell convention: a cleared bit means no connection. A term with no connections is therefore high. A term that connects both literals of one source is always low. The configuration is shifted in one bit per clock while the load-enable input is high. A valid flag shows when a complete image is in place. From the source inputs to the term outputs the path is purely combinational.

Top module: `pla_and_or_array`

## Requirements
- R1: Connection bit index = ((m*9)+t)*40 + 2*j + p, where m is the macrocell (0..15) and t is the term (0..7 sum terms, 8 the control term). Source j 0..3 is ded_in[j] and source j 4..19 is fb_in[j-4]. p=0 selects the true literal and p=1 the complement literal. A bit value of 1 means connected.
- R2: While load_en is high, each rising clock shifts ser_din into index 0 and moves every stored bit up by one index. After exactly 5760 shifts, the first bit sent sits at index 5759.
- R3: A product term is the AND of all the literals its connection bits select.
- R4: A product term with no connection bits set evaluates high.
- R5: A product term that connects both the true and the complement literal of any one source evaluates low, whatever the inputs are.
- R6: sum_out[m] is the OR of terms 0..7 of macrocell m, and ctl_out[m] is term 8 of macrocell m.
- R7: cfg_valid is low after reset and low while load_en is high. It is high only when load_en is low and at least 5760 bits were shifted in the most recent load_en high period, so a shorter load leaves it low.
- R8: While load_en is low, the stored configuration does not change, whatever ser_din does.
- R9: sum_out and ctl_out follow ded_in and fb_in within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shift chain |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Shift enable for the serial configuration load |
| ser_din | input | 1 | Serial configuration bit |
| ded_in | input | 4 | Dedicated input pins (sources 0..3) |
| fb_in | input | 16 | Macrocell feedback (sources 4..19) |
| sum_out | output | 16 | OR of the eight sum terms of each macrocell |
| ctl_out | output | 16 | Clock/output-enable term of each macrocell |
| cfg_valid | output | 1 | A complete configuration is loaded |

## Verification
The case that is hardest to reach from the ports is a specific connection pattern inside one of 144 terms, such as a conflicting literal pair or a fully empty term. Such a pattern only exists after a complete 5760-bit serial image has been shifted in the right order. The bench generates whole images from an index formula: all clear, all set, a sparse hash and a targeted pattern that places one literal per term with alternating polarity and gives alternate macrocells a conflicting control term. After each load, random and extreme input vectors are driven and compared against a behavioural evaluation of the same image. A short load and a hold period with a toggling ser_din cover the validity flag and configuration retention.

// File: rtl/pla_pkg.sv
package pla_pkg;
    parameter int N_DED = 4;
    parameter int N_MC  = 16;
    parameter int N_SUM = 8;

    localparam int N_PT     = N_SUM + 1;
    localparam int N_SRC    = N_DED + N_MC;
    localparam int N_LIT    = 2 * N_SRC;
    localparam int N_TERMS  = N_MC * N_PT;
    localparam int CFG_BITS = N_TERMS * N_LIT;
    localparam int CNT_W    = $clog2(CFG_BITS + 1);

    typedef logic [N_LIT-1:0] lit_vec_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev_le;
    } load_state_t;

    // even index: true literal, odd index: complement literal
    function automatic lit_vec_t make_lits(input logic [N_SRC-1:0] src);
        lit_vec_t v;
        for (int j = 0; j < N_SRC; j++) begin
            v[2*j]   = src[j];
            v[2*j+1] = ~src[j];
        end
        return v;
    endfunction

    function automatic logic has_conflict(input lit_vec_t c);
        logic r;
        r = 1'b0;
        for (int j = 0; j < N_SRC; j++)
            r = r | (c[2*j] & c[2*j+1]);
        return r;
    endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain
    import pla_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic                ser_din,
    output logic [CFG_BITS-1:0] cfg_q,
    output logic                cfg_valid
);
    load_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            st.cnt     <= '0;
            st.prev_le <= 1'b0;
        end else begin
            st.prev_le <= load_en;
            if (load_en) begin
                cfg_q <= {cfg_q[CFG_BITS-2:0], ser_din};
                if (!st.prev_le)
                    st.cnt <= CNT_W'(1);
                else if (st.cnt != CNT_W'(CFG_BITS))
                    st.cnt <= st.cnt + CNT_W'(1);
            end
        end
    end

    assign cfg_valid = !load_en && (st.cnt == CNT_W'(CFG_BITS));

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(cfg_q));

    a_r2_shift_entry: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cfg_q[0] == $past(ser_din));

    a_r7_valid_after_load: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> $fell(load_en));
endmodule

// File: rtl/pla_term.sv
module pla_term
    import pla_pkg::*;
(
    input  lit_vec_t conn,
    input  lit_vec_t lits,
    output logic     pt
);
    // unconnected literals are masked to 1 before the AND
    assign pt = &(lits | ~conn);
endmodule

// File: rtl/pla_or_group.sv
module pla_or_group #(
    parameter int W = 8
) (
    input  logic [W-1:0] terms,
    output logic         any
);
    assign any = |terms;
endmodule

// File: rtl/pla_and_or_array.sv
module pla_and_or_array
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             ser_din,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_MC-1:0]  fb_in,
    output logic [N_MC-1:0]  sum_out,
    output logic [N_MC-1:0]  ctl_out,
    output logic             cfg_valid
);
    logic [CFG_BITS-1:0]       cfg_q;
    logic [N_SRC-1:0]          src;
    lit_vec_t                  lits;
    logic [N_MC-1:0][N_PT-1:0] pt;

    assign src  = {fb_in, ded_in};
    assign lits = make_lits(src);

    pla_cfg_chain u_chain (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .ser_din   (ser_din),
        .cfg_q     (cfg_q),
        .cfg_valid (cfg_valid)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        for (genvar t = 0; t < N_PT; t++) begin : g_pt
            lit_vec_t conn;
            assign conn = cfg_q[(m*N_PT + t)*N_LIT +: N_LIT];

            pla_term u_term (
                .conn (conn),
                .lits (lits),
                .pt   (pt[m][t])
            );

            a_r4_empty_high: assert property (@(posedge clk) disable iff (rst)
                (conn == '0) |-> pt[m][t]);

            a_r5_conflict_low: assert property (@(posedge clk) disable iff (rst)
                has_conflict(conn) |-> !pt[m][t]);
        end

        pla_or_group #(.W(N_SUM)) u_or (
            .terms (pt[m][N_SUM-1:0]),
            .any   (sum_out[m])
        );
        assign ctl_out[m] = pt[m][N_SUM];
    end
endmodule

// File: tb/test_pla_and_or_array.sv
`timescale 1ns/1ps
module test_pla_and_or_array;
    import pla_pkg::*;

    logic clk = 0;
    logic rst = 1;
    logic load_en = 0;
    logic ser_din = 0;
    logic [N_DED-1:0] ded_in = '0;
    logic [N_MC-1:0]  fb_in = '0;
    logic [N_MC-1:0]  sum_out, ctl_out;
    logic             cfg_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pla_and_or_array i_pla_and_or_array (
        .clk(clk), .rst(rst), .load_en(load_en), .ser_din(ser_din),
        .ded_in(ded_in), .fb_in(fb_in), .sum_out(sum_out),
        .ctl_out(ctl_out), .cfg_valid(cfg_valid)
    );

    // behavioural model: queue of bits shifted in the current load
    bit q[$];
    bit m_prev_le = 0;
    bit ref_cfg [CFG_BITS];

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_prev_le = 0;
        end else begin
            if (load_en) begin
                if (!m_prev_le) q.delete();
                q.push_back(ser_din);
            end
            m_prev_le = load_en;
        end
    end

    function automatic bit model_valid();
        return !load_en && (q.size() >= CFG_BITS);
    endfunction

    task automatic snapshot();
        int n = q.size();
        for (int i = 0; i < CFG_BITS; i++) ref_cfg[i] = q[n-1-i];
    endtask

    function automatic bit ref_term(int m, int t, logic [N_SRC-1:0] s);
        int base = (m*N_PT + t)*N_LIT;
        bit r = 1;
        for (int j = 0; j < N_SRC; j++) begin
            if (ref_cfg[base + 2*j]     && !s[j]) r = 0;
            if (ref_cfg[base + 2*j + 1] &&  s[j]) r = 0;
        end
        return r;
    endfunction

    function automatic bit gen_bit(int mode, int k);
        int lit = k % N_LIT;
        int ti  = k / N_LIT;
        int t   = ti % N_PT;
        int m   = ti / N_PT;
        int h;
        case (mode)
            0: return 0;
            1: return 1;
            2: begin
                h = (k*37 + 11) ^ (k >> 3);
                return (h % 29) == 0;
            end
            default: begin
                if (t < N_SUM) return lit == 2*((m + t) % N_SRC) + (t & 1);
                if (m % 2 == 0) return (lit == 0) || (lit == 1);
                return 0;
            end
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cfg(int mode, int nbits);
        for (int k = CFG_BITS-1; k >= CFG_BITS-nbits; k--) begin
            @(negedge clk);
            load_en = 1;
            ser_din = gen_bit(mode, k);
        end
        @(negedge clk);
        load_en = 0;
        ser_din = 0;
    endtask

    task automatic apply_and_check(string req, logic [N_DED-1:0] d, logic [N_MC-1:0] f);
        logic [N_SRC-1:0] s;
        logic [N_MC-1:0] es, ec;
        @(negedge clk);
        ded_in = d;
        fb_in  = f;
        s = {f, d};
        #2;
        for (int m = 0; m < N_MC; m++) begin
            es[m] = 0;
            for (int t = 0; t < N_SUM; t++) es[m] = es[m] | ref_term(m, t, s);
            ec[m] = ref_term(m, N_SUM, s);
        end
        chk({req, " R6 sum"}, 32'(sum_out), 32'(es));
        chk({req, " R6 ctl"}, 32'(ctl_out), 32'(ec));
        chk("R7 valid", 32'(cfg_valid), 32'(model_valid()));
    endtask

    task automatic pattern_set(string req);
        apply_and_check(req, '0, '0);
        apply_and_check(req, '1, '1);
        for (int i = 0; i < 12; i++)
            apply_and_check(req, N_DED'($urandom), N_MC'($urandom));
    endtask

    initial begin
        #1_900_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #2 chk("R7 reset", 32'(cfg_valid), 32'(0));

        // R7: short load leaves valid low
        load_cfg(1, 100);
        #2 chk("R7 short load", 32'(cfg_valid), 32'(0));

        // R4: empty terms everywhere
        load_cfg(0, CFG_BITS);
        #2 chk("R7 full load", 32'(cfg_valid), 32'(1));
        snapshot();
        pattern_set("R4");

        // R5: every term connects both literals of every source
        load_cfg(1, CFG_BITS);
        snapshot();
        pattern_set("R5");

        // R1/R2: targeted placement with polarity and conflict control terms
        load_cfg(3, CFG_BITS);
        snapshot();
        pattern_set("R1 R2");

        // R3: sparse hash image
        load_cfg(2, CFG_BITS);
        snapshot();
        pattern_set("R3");

        // R8: ser_din toggles with load_en low, configuration must hold
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_din = ~ser_din;
        end
        ser_din = 0;
        pattern_set("R8");

        // R9: outputs change between clock edges
        @(posedge clk);
        #1;
        ded_in = ~ded_in;
        fb_in  = ~fb_in;
        #1;
        begin
            logic [N_SRC-1:0] s;
            logic [N_MC-1:0] es;
            s = {fb_in, ded_in};
            for (int m = 0; m < N_MC; m++) begin
                es[m] = 0;
                for (int t = 0; t < N_SUM; t++) es[m] = es[m] | ref_term(m, t, s);
            end
            chk("R9 same cycle", 32'(sum_out), 32'(es));
        end

        // R7: valid drops during a new load
        @(negedge clk);
        load_en = 1;
        #2 chk("R7 low while loading", 32'(cfg_valid), 32'(0));
        @(negedge clk);
        load_en = 0;
        #2 chk("R7 low after 1 bit", 32'(cfg_valid), 32'(0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule